// File: doc/BRIEF.md
# Delayed Dual-Edge Pulse Generator

This block watches a slow reference clock that arrives from outside the chip, with no known phase relation to the local fast clock. It brings the reference into the fast-clock domain through a flop synchroniser, finds its rising and falling transitions, and emits a pulse of fixed width a fixed number of fast-clock cycles after each transition. Typical use is making short strobes at a set offset into each phase of a slow bus clock, for example a 25 ns strobe about 200 ns after every transition of a 1 MHz clock when the fast clock runs at 40 MHz.

Each transition direction has its own enable. The two qualified triggers are ORed, so the block can fire on both transitions or on only one. Delay and width are parameters counted in fast-clock cycles. The delay includes the synchroniser latency, so the offset from the first fast-clock edge that sees the new level to the pulse is exactly the delay parameter. Triggers that arrive while earlier pulses are still waiting are held in a delay line. Every trigger therefore produces its own pulse, as long as the transitions are more than one pulse width apart.

Top module: `phase_edge_pulser`

## Requirements
- R1: While `rst_n` is low (active-low, asynchronous), `pulse_out` is 0.
- R2: Call fast-clock rising edge k the first edge at which `ref_clk_in` has its new level. If `ref_clk_in` goes 0 to 1 and `rise_en` is 1, `pulse_out` becomes 1 at edge k+DELAY_CYC (DELAY_CYC must be at least SYNC_STAGES; default 8).
- R3: If `ref_clk_in` goes 1 to 0 and `fall_en` is 1, `pulse_out` becomes 1 at edge k+DELAY_CYC, with k defined as in R2.
- R4: A pulse from an isolated transition stays 1 for exactly WIDTH_CYC fast-clock cycles (default 1) and then returns to 0.
- R5: The enables are active high and are looked at in the cycle the transition is detected. A rising transition with `rise_en`=0 gives no pulse. A falling transition with `fall_en`=0 gives no pulse. The other direction is not affected.
- R6: With both enables at 0, `pulse_out` stays 0 whatever `ref_clk_in` does.
- R7: Transitions spaced more than WIDTH_CYC cycles apart each produce their own pulse at their own R2/R3 time. This holds even when a later transition arrives before the pulse of an earlier one has started.
- R8: The level `ref_clk_in` holds when reset is released is not a transition. If `ref_clk_in` is 1 at reset release and stays 1, no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Slow external reference clock, asynchronous to clk |
| rise_en | input | 1 | 1 = rising transitions of ref_clk_in trigger a pulse |
| fall_en | input | 1 | 1 = falling transitions of ref_clk_in trigger a pulse |
| pulse_out | output | 1 | Delayed pulse, WIDTH_CYC cycles wide |

## Verification
A fault in the delay line or the tap window shows as a pulse that starts on the wrong fast-clock edge or has the wrong width. This is visible DELAY_CYC cycles after the transition that caused it. A lost or duplicated queued trigger shows as a missing or extra pulse when closely spaced transitions are drained. A wrong enable decode or a stale edge-history flop shows as a pulse with no expected entry, or an expected entry that never appears. A priming fault shows within a few cycles of reset release, as a pulse with no transition behind it.

// File: rtl/phase_edge_pulser_pkg.sv
package phase_edge_pulser_pkg;

    localparam int FILL_W = 4;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } edge_kind_e;

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic              prev;
    } edge_state_t;

endpackage

// File: rtl/pulser_sync_chain.sv
module pulser_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            if (i == 0) begin
                chain_d[i] = din;
            end else begin
                chain_d[i] = chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pulser_edge_qualify.sv
module pulser_edge_qualify
    import phase_edge_pulser_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_en,
    input  logic fall_en,
    output logic trig,
    output logic primed
);
    localparam int FULL = STAGES + 1;
    localparam logic [FILL_W-1:0] FULL_V = FILL_W'(FULL);

    edge_state_t st_d;
    edge_state_t st_q;
    edge_kind_e  kind;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        if (st_q.fill != FULL_V) begin
            st_d.fill = st_q.fill + 1'b1;
        end
        primed = (st_q.fill == FULL_V);
        kind   = EV_NONE;
        if (primed) begin
            if (lvl && !st_q.prev) begin
                kind = EV_RISE;
            end else if (!lvl && st_q.prev) begin
                kind = EV_FALL;
            end
        end
        trig = ((kind == EV_RISE) && rise_en) || ((kind == EV_FALL) && fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: with both enables low no trigger can leave this stage
    a_r6_masked_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en && !fall_en) |-> !trig);
endmodule

// File: rtl/pulser_event_delay.sv
module pulser_event_delay #(
    parameter int BASE  = 6,
    parameter int WIDTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int HLEN = BASE + WIDTH;

    typedef struct packed {
        logic [HLEN-1:0] hist;
        logic            pulse;
    } dly_state_t;

    dly_state_t    st_d;
    dly_state_t    st_q;
    logic [HLEN:0] taps;

    always_comb begin
        taps = {st_q.hist, trig};
        for (int i = 0; i < HLEN; i++) begin
            st_d.hist[i] = taps[i];
        end
        st_d.pulse = |taps[BASE +: WIDTH];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

    // Checker state: triggers accepted minus pulses started
    int pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 0;
        end else begin
            pend_q <= pend_q + int'(trig) - int'(st_d.pulse && !st_q.pulse);
        end
    end

    // R7: every pulse start is backed by a trigger not yet consumed
    a_r7_no_unsourced_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.pulse && !st_q.pulse) |-> ((pend_q + int'(trig)) > 0));

    // R4: an empty delay line with no new trigger ends any pulse
    a_r4_empty_line_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hist == '0 && !trig) |=> !pulse);
endmodule

// File: rtl/phase_edge_pulser.sv
module phase_edge_pulser #(
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_CYC   = 8,
    parameter int WIDTH_CYC   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk_in,
    input  logic rise_en,
    input  logic fall_en,
    output logic pulse_out
);
    localparam int TAP_BASE = DELAY_CYC - SYNC_STAGES;

    logic ref_lvl;
    logic edge_trig;
    logic primed;

    pulser_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ref_clk_in),
        .dout (ref_lvl)
    );

    pulser_edge_qualify #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (ref_lvl),
        .rise_en(rise_en),
        .fall_en(fall_en),
        .trig   (edge_trig),
        .primed (primed)
    );

    pulser_event_delay #(.BASE(TAP_BASE), .WIDTH(WIDTH_CYC)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (edge_trig),
        .pulse(pulse_out)
    );

    // R2: once primed, the synchronised level lags the pin by SYNC_STAGES edges
    a_r2_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (ref_lvl == $past(ref_clk_in, SYNC_STAGES)));

    // R8: nothing leaves the block before edge history holds real samples
    a_r8_quiet_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> !pulse_out);
endmodule

// File: tb/phase_edge_pulser_test.sv
`timescale 1ns/1ps
module phase_edge_pulser_test;
    localparam int SYNC_N = 2;
    localparam int DLY    = 8;
    localparam int WID    = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk_in = 1'b0;
    logic rise_en = 1'b1;
    logic fall_en = 1'b1;
    logic pulse_out;

    phase_edge_pulser #(.SYNC_STAGES(SYNC_N), .DELAY_CYC(DLY), .WIDTH_CYC(WID)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_clk_in(ref_clk_in),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .pulse_out (pulse_out)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    start;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   run = 0;
    int   pulses_seen = 0;
    int   mark = 0;
    bit   last = 1'b0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on each pulse start, checks width at the end
    always @(negedge clk) begin
        if (mon_on) begin
            if (pulse_out && !last) begin
                run = 1;
                pulses_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "pulse with no expected transition", cyc, -1);
                end else begin
                    cur = exp_q.pop_front();
                    check(cyc == cur.start, cur.tag, "pulse start cycle", cyc, cur.start);
                end
            end else if (pulse_out) begin
                run++;
            end else if (last) begin
                check(run == WID, "R4", "pulse width", run, WID);
            end
            last = pulse_out;
        end
    end

    // Driver: changes the reference level and pushes the expected start cycle
    task automatic drive(input logic lvl, input string tag, input int gap);
        @(negedge clk);
        ref_clk_in = lvl;
        if ((lvl && rise_en) || (!lvl && fall_en)) begin
            exp_q.push_back('{cyc + 1 + DLY, tag});
        end
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (DLY + WID + 6) @(negedge clk);
        check(exp_q.size() == 0, tag, "expected pulses left over", exp_q.size(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(pulse_out == 1'b0, "R1", "output during reset", int'(pulse_out), 0);
        ref_clk_in = 1'b1;
        repeat (3) @(negedge clk);
        check(pulse_out == 1'b0, "R1", "output during reset, ref high", int'(pulse_out), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (DLY + 10) @(negedge clk);
        check(pulses_seen == 0, "R8", "pulses from level at reset release", pulses_seen, 0);

        // R2 / R3: isolated transitions, both enabled
        drive(1'b0, "R3", 20);
        drive(1'b1, "R2", 20);
        drive(1'b0, "R3", 20);
        drive(1'b1, "R2", 20);
        drain("R4");

        // R7: transitions closer than the delay, queued separately
        mark = pulses_seen;
        drive(1'b0, "R7", 3);
        drive(1'b1, "R7", 3);
        drive(1'b0, "R7", 2);
        drive(1'b1, "R7", 2);
        drain("R7");
        check(pulses_seen - mark == 4, "R7", "pulse count for queued transitions",
              pulses_seen - mark, 4);

        // R5: rising transitions masked
        @(negedge clk);
        rise_en = 1'b0;
        mark = pulses_seen;
        drive(1'b0, "R5", 12);
        drive(1'b1, "R5", 12);
        drive(1'b0, "R5", 12);
        drive(1'b1, "R5", 12);
        drain("R5");
        check(pulses_seen - mark == 2, "R5", "pulses with rise_en=0", pulses_seen - mark, 2);

        // R5: falling transitions masked
        @(negedge clk);
        rise_en = 1'b1;
        fall_en = 1'b0;
        mark = pulses_seen;
        drive(1'b0, "R5", 12);
        drive(1'b1, "R5", 12);
        drive(1'b0, "R5", 12);
        drive(1'b1, "R5", 12);
        drain("R5");
        check(pulses_seen - mark == 2, "R5", "pulses with fall_en=0", pulses_seen - mark, 2);

        // R6: both masked
        @(negedge clk);
        rise_en = 1'b0;
        mark = pulses_seen;
        drive(1'b0, "R6", 9);
        drive(1'b1, "R6", 9);
        drive(1'b0, "R6", 4);
        drive(1'b1, "R6", 4);
        drain("R6");
        check(pulses_seen - mark == 0, "R6", "pulses with both enables low",
              pulses_seen - mark, 0);
        check(pulse_out == 1'b0, "R6", "output idle with both enables low",
              int'(pulse_out), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule